// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches a set of asynchronous external interrupt pins (two by default) and turns each into a registered request toward an interrupt controller. Every channel has its own trigger-type bit. With the bit at 1 the channel latches a falling edge on its pin. With the bit at 0 the channel asserts while the pin is held low. The request flag drives the channel's request output directly.

In falling-edge mode the flag is sticky. It stays set until the controller pulses that channel's acknowledge, or until software clears it through the write port. Software may also set it to raise a request by hand. In low-level mode the flag is not a latch. It follows the inverted, synchronized pin, and both acknowledge and software flag writes are ignored.

A single write strobe loads all type bits and all flag values at once. The current type bits are visible on an output. Each pin passes through a two-stage synchronizer. A falling edge is found by comparing the newest synchronized sample with the one before it. Reset is applied asynchronously and released synchronously inside the block.

Top module: `ext_irq_detect`

## Requirements
- R1: While reset is applied, and after it is released with all pins high and no writes, `irq_o` and `type_o` are all 0.
- R2: When `cfg_we_i` is 1 at a rising clock edge, `type_o` takes the value of `wr_type_i` at that edge. A type bit of 1 selects falling-edge triggering and 0 selects low-level triggering.
- R3: In falling-edge mode, a high-to-low change on a channel's pin sets that channel's `irq_o` bit on the third rising clock edge that samples the new low level.
- R4: In falling-edge mode, a set request stays at 1 after the pin returns high, as long as there is no acknowledge and no software clear.
- R5: In falling-edge mode, an `ack_i` pulse for a channel clears that channel's request at the next rising edge. An acknowledge in the same cycle as a software write also wins over that write.
- R6: In low-level mode, `irq_o` for a channel equals the inverse of the pin level, delayed by three rising clock edges.
- R7: In low-level mode, `ack_i` pulses and software writes of `wr_flag_i` have no effect on `irq_o`.
- R8: In falling-edge mode, a write with `cfg_we_i` loads the channel's request from `wr_flag_i` at that edge. Writing 1 raises a request and writing 0 removes one.
- R9: In falling-edge mode, a detected falling edge sets the request even when the same cycle carries an acknowledge or a software write of 0.
- R10: Channels are independent. The pin, acknowledge and mode of one channel never change another channel's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_CH | Asynchronous external interrupt pins, idle high |
| ack_i | input | N_CH | Per-channel single-cycle vector acknowledge |
| cfg_we_i | input | 1 | Write strobe for type bits and request flags |
| wr_type_i | input | N_CH | Type values written (1 falling edge, 0 low level) |
| wr_flag_i | input | N_CH | Request flag values written (honoured in edge mode only) |
| type_o | output | N_CH | Current trigger-type bits |
| irq_o | output | N_CH | Request flags toward the interrupt controller |

## Verification
Type bits, software flag writes and acknowledges take effect at the next rising edge. A pin change reaches `irq_o` three rising edges after it is first sampled: two synchronizer stages, then the flag register. The bench drives every input on the falling edge. It advances a reference model by exactly one rising edge, using the inputs present at that edge, and compares both outputs at the next falling edge. This way each result is checked in the cycle it is due and not one earlier or later. Directed sequences line up an edge detection with a clear or an acknowledge in the same cycle, and long random runs mix modes, writes and pin activity.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_e;

  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/ext_irq_rst_sync.sv
module ext_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_pin_sync.sv
module ext_irq_pin_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic fall
);
  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;
  logic             prev_q;
  logic             prev_d;

  // stage 0 takes the pin, each later stage its predecessor
  genvar s;
  generate
    for (s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stage_d[s] = pin;
      end else begin : g_next
        assign stage_d[s] = stage_q[s-1];
      end
    end
  endgenerate

  always_comb begin
    prev_d = stage_q[DEPTH-1];
  end

  // idle-high reset value avoids a false edge or level at start-up
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      stage_q <= stage_d;
      prev_q  <= prev_d;
    end
  end

  assign lvl  = stage_q[DEPTH-1];
  assign fall = prev_q & ~stage_q[DEPTH-1];
endmodule

// File: rtl/ext_irq_flag.sv
module ext_irq_flag
  import ext_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  trig_e trig,
  input  logic  lvl,
  input  logic  fall,
  input  logic  ack,
  input  logic  wr_en,
  input  logic  wr_val,
  output logic  flag
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_d = flag_q;
    if (trig == TRIG_LEVEL) begin
      flag_d = ~lvl;
    end else begin
      if (wr_en) flag_d = wr_val;
      if (ack)   flag_d = 1'b0;
      if (fall)  flag_d = 1'b1;
    end
  end

  always_comb begin
    flag_en = (trig == TRIG_LEVEL) | wr_en | ack | fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int N_CH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] pin_i,
  input  logic [N_CH-1:0] ack_i,
  input  logic            cfg_we_i,
  input  logic [N_CH-1:0] wr_type_i,
  input  logic [N_CH-1:0] wr_flag_i,
  output logic [N_CH-1:0] type_o,
  output logic [N_CH-1:0] irq_o
);
  logic            rst_sync_n;
  logic [N_CH-1:0] type_q;
  logic [N_CH-1:0] type_d;
  logic [N_CH-1:0] lvl_w;
  logic [N_CH-1:0] fall_w;

  ext_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    type_d = cfg_we_i ? wr_type_i : type_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   type_q <= '0;
    else if (cfg_we_i) type_q <= type_d;
  end

  genvar c;
  generate
    for (c = 0; c < N_CH; c++) begin : g_ch
      ext_irq_pin_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .pin   (pin_i[c]),
        .lvl   (lvl_w[c]),
        .fall  (fall_w[c])
      );

      ext_irq_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .trig   (trig_e'(type_q[c])),
        .lvl    (lvl_w[c]),
        .fall   (fall_w[c]),
        .ack    (ack_i[c]),
        .wr_en  (cfg_we_i),
        .wr_val (wr_flag_i[c]),
        .flag   (irq_o[c])
      );
    end
  endgenerate

  assign type_o = type_q;
endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk #(
  parameter int N_CH = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] lvl,
  input logic [N_CH-1:0] fall,
  input logic [N_CH-1:0] trig,
  input logic [N_CH-1:0] irq,
  input logic [N_CH-1:0] ack,
  input logic [N_CH-1:0] wr_type,
  input logic            cfg_we
);
  // R2: type bits load on a write
  a_r2_type_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (trig == $past(wr_type)));

  genvar c;
  generate
    for (c = 0; c < N_CH; c++) begin : g_chk
      // R9: a detected edge always sets the request
      a_r9_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (trig[c] && fall[c]) |=> irq[c]);
      // R5: acknowledge clears unless an edge arrives
      a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (trig[c] && ack[c] && !fall[c]) |=> !irq[c]);
      // R4: pending request holds without ack or write
      a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (trig[c] && irq[c] && !ack[c] && !cfg_we) |=> irq[c]);
      // R6: level mode follows the synchronized pin inverted
      a_r6_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig[c]) |=> (irq[c] == !$past(lvl[c])));
    end
  endgenerate
endmodule

bind ext_irq_detect ext_irq_detect_chk #(.N_CH(N_CH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .lvl     (lvl_w),
  .fall    (fall_w),
  .trig    (type_o),
  .irq     (irq_o),
  .ack     (ack_i),
  .wr_type (wr_type_i),
  .cfg_we  (cfg_we_i)
);

// File: tb/ext_irq_detect_test.sv
module ext_irq_detect_test;
  localparam int N = 2;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] pin_i, ack_i, wr_type_i, wr_flag_i;
  logic         cfg_we_i;
  logic [N-1:0] type_o, irq_o;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference state: sampling stages, previous sample, flags, types
  logic [N-1:0] m_s1, m_s2, m_prev, m_flag, m_type;

  ext_irq_detect #(.N_CH(N)) uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .ack_i(ack_i),
    .cfg_we_i(cfg_we_i), .wr_type_i(wr_type_i), .wr_flag_i(wr_flag_i),
    .type_o(type_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic next_flag(logic typ, logic cur, logic s2, logic prv,
                                     logic ack, logic we, logic wv);
    logic r;
    if (!typ) return ~s2;
    r = cur;
    if (we)        r = wv;
    if (ack)       r = 1'b0;
    if (prv & ~s2) r = 1'b1;
    return r;
  endfunction

  task automatic check(string t, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", t, act, exp, $time);
    end
  endtask

  task automatic tick();
    for (int c = 0; c < N; c++)
      m_flag[c] = next_flag(m_type[c], m_flag[c], m_s2[c], m_prev[c],
                            ack_i[c], cfg_we_i, wr_flag_i[c]);
    if (cfg_we_i) m_type = wr_type_i;
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = pin_i;
    @(negedge clk);
    check(tag, irq_o, m_flag);
    check("R2", type_o, m_type);
  endtask

  task automatic idle();
    ack_i = '0; cfg_we_i = 1'b0; wr_type_i = '0; wr_flag_i = '0;
  endtask

  task automatic wr(logic [N-1:0] t, logic [N-1:0] f);
    cfg_we_i = 1'b1; wr_type_i = t; wr_flag_i = f;
    tick();
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; pin_i = '1; idle();
    repeat (4) @(negedge clk);
    check("R1", irq_o, '0);
    check("R1", type_o, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_s1 = '1; m_s2 = '1; m_prev = '1; m_flag = '0; m_type = '0;
    check("R1", irq_o, '0);
    check("R1", type_o, '0);

    // R2 then R3: edge mode, falling edge on channel 0
    tag = "R2"; wr(2'b11, 2'b00);
    tag = "R3"; pin_i[0] = 1'b0;
    repeat (4) tick();
    check("R3", irq_o[0], 1'b1);
    // R4: pin back high, flag stays
    tag = "R4"; pin_i[0] = 1'b1;
    repeat (5) tick();
    check("R4", irq_o[0], 1'b1);
    // R8: software sets channel 1
    tag = "R8"; wr(2'b11, 2'b11);
    check("R8", irq_o, 2'b11);
    // R5 and R10: ack channel 0 leaves channel 1 pending
    tag = "R5"; ack_i = 2'b01; tick(); idle();
    check("R5", irq_o[0], 1'b0);
    check("R10", irq_o[1], 1'b1);
    // R8: software clear
    tag = "R8"; wr(2'b11, 2'b00);
    check("R8", irq_o, 2'b00);
    // R5: ack beats a software set
    tag = "R5"; ack_i = 2'b10; cfg_we_i = 1'b1; wr_type_i = 2'b11; wr_flag_i = 2'b10;
    tick(); idle();
    check("R5", irq_o[1], 1'b0);
    // R9: edge collides with ack and software clear on channel 1
    tag = "R9"; pin_i[1] = 1'b0; tick(); tick();
    ack_i = 2'b10; cfg_we_i = 1'b1; wr_type_i = 2'b11; wr_flag_i = 2'b00;
    tick(); idle();
    check("R9", irq_o[1], 1'b1);
    pin_i[1] = 1'b1; tick();
    // R6: level mode follows pin with three-edge delay
    tag = "R6"; wr(2'b00, 2'b00);
    repeat (3) tick();
    pin_i = 2'b01;
    repeat (2) tick();
    check("R6", irq_o[1], 1'b0);
    tick();
    check("R6", irq_o, 2'b10);
    // R7: ack and flag writes ignored in level mode
    tag = "R7"; ack_i = 2'b11; tick(); idle();
    wr(2'b00, 2'b01);
    check("R7", irq_o, 2'b10);
    pin_i = 2'b11; repeat (3) tick();
    check("R7", irq_o, 2'b00);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 4) == 0) pin_i = N'($urandom);
      ack_i = (($urandom % 6) == 0) ? N'($urandom) : '0;
      cfg_we_i = (($urandom % 12) == 0);
      wr_type_i = (($urandom % 4) == 0) ? N'($urandom) : '1;
      wr_flag_i = N'($urandom);
      tag = (m_type == '1) ? "R3" : ((m_type == '0) ? "R6" : "R10");
      tick();
    end
    idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule